// File: doc/BRIEF.md
# ULPI Register Access Sequencer

This block is the link-side engine that reads and writes PHY registers across an 8-bit ULPI bus. It runs on the clock supplied by the PHY. A request names an operation (read or write), a register address and, for writes, a data byte. The block turns each request into the transmit-command byte sequence on the bus. It waits on the PHY's NXT throttle, gives up the bus whenever the PHY takes it with DIR, and returns a response carrying the read byte.

Short addresses go out in the immediate form, where the address sits inside the command byte. Addresses from the extended code upward are sent automatically in the extended form: the command byte carries the escape code and a separate address byte follows. For reads the block manages the DIR-driven turnaround. If the PHY grabs the bus before the command has been taken, the access starts again from its first byte once the bus comes back.

Both the request and response sides use valid/ready. A request is taken on a clock where `req_valid` and `req_ready` are both high, and its fields must stay stable while it waits. A response stays presented, with its data unchanged, until `rsp_ready` is high. No new request is taken while a response is pending.

Top module: `ulpi_regseq`

## Requirements
- R1: A write to an address below 0x2F sends two bytes: the command {2'b10, addr[5:0]}, then the data byte.
- R2: A write to an address of 0x2F or above sends three bytes: the command 0xAF, then the full 8-bit address, then the data byte.
- R3: A read sends the command {2'b11, addr[5:0]} for addresses below 0x2F. For addresses of 0x2F or above it sends 0xEF followed by the address byte.
- R4: Each transmitted byte stays on `ulpi_data_o` until a clock where NXT is high and DIR is low. A byte with NXT low is sent again unchanged.
- R5: After a write's last byte is accepted, `ulpi_stp` is high for exactly one clock with `ulpi_data_o` at zero. The response follows on the next clock.
- R6: After a read's last byte is accepted, the first clock with DIR high is skipped as turnaround. The byte on `ulpi_data_i` in the following clock is returned as `rsp_rdata`.
- R7: If DIR is high at a clock while the block is sending, nothing is accepted. The access restarts from its command byte once the bus is owned again.
- R8: `ulpi_data_oe` is high exactly when DIR is low in both the current and the previous clock. While it is high and no byte is being sent, `ulpi_data_o` is zero.
- R9: `req_ready` is high only when the block is idle and owns the bus under R8.
- R10: `rsp_valid` and `rsp_rdata` hold until `rsp_ready`. A read response waits until DIR has fallen. A write response carries zero data.
- R11: After reset the block is idle and owns the bus (given DIR low), with `ulpi_stp` and `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this clock when valid |
| req_rd | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Access finished, response presented |
| rsp_ready | input | 1 | Response consumed this clock |
| rsp_rdata | output | 8 | Read data (zero for writes) |
| ulpi_dir | input | 1 | PHY owns the data bus when high |
| ulpi_nxt | input | 1 | PHY throttle: current byte accepted |
| ulpi_data_i | input | 8 | Data bus, PHY to link |
| ulpi_data_o | output | 8 | Data bus, link to PHY |
| ulpi_data_oe | output | 1 | Link drives the data bus |
| ulpi_stp | output | 1 | Stop strobe ending a write |

## Verification
The assertions assume the PHY keeps to the bus rules. During a read it holds DIR high from the turnaround clock through the data clock. While DIR is low it pulses NXT only in reply to a byte being offered. They also assume the requester keeps its fields stable while `req_valid` waits. The stimulus derives every PHY action from the bench's own model of where the access stands, so DIR rises only in idle, as an abort while the command byte is still pending, or as the read reply. The request is presented unchanged until the model sees it taken.

// File: rtl/ulpi_regseq_pkg.sv
package ulpi_regseq_pkg;
  localparam int BYTE_W  = 8;
  localparam int OPC_W   = 2;
  localparam int SHORT_W = BYTE_W - OPC_W;
  localparam int IDX_W   = 2;

  localparam logic [OPC_W-1:0] OPC_WRITE = 2'b10;
  localparam logic [OPC_W-1:0] OPC_READ  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_HOLD,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_RD_END,
    ST_STOP,
    ST_RESP
  } seq_state_e;

  typedef struct packed {
    logic              rd;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] wdata;
  } access_t;
endpackage

// File: rtl/ulpi_regseq_enc.sv
module ulpi_regseq_enc
  import ulpi_regseq_pkg::*;
#(
  parameter logic [SHORT_W-1:0] EXT_CODE = 6'h2F
) (
  input  access_t           acc,
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              last
);
  localparam logic [BYTE_W-1:0] EXT_LIMIT = {{OPC_W{1'b0}}, EXT_CODE};

  logic              ext;
  logic [IDX_W-1:0]  last_idx;
  logic [BYTE_W-1:0] cmd_byte;

  always_comb begin
    ext      = (acc.addr >= EXT_LIMIT);
    cmd_byte = {acc.rd ? OPC_READ : OPC_WRITE,
                ext ? EXT_CODE : acc.addr[SHORT_W-1:0]};
    last_idx = {{(IDX_W-1){1'b0}}, ext} + {{(IDX_W-1){1'b0}}, ~acc.rd};
    last     = (idx == last_idx);
    unique case (idx)
      2'd0:    tx_byte = cmd_byte;
      2'd1:    tx_byte = ext ? acc.addr : acc.wdata;
      default: tx_byte = acc.wdata;
    endcase
  end
endmodule

// File: rtl/ulpi_regseq_own.sv
module ulpi_regseq_own (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  output logic own
);
  logic dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir;
  end

  assign own = ~dir & ~dir_q;
endmodule

// File: rtl/ulpi_regseq_fsm.sv
module ulpi_regseq_fsm
  import ulpi_regseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             rd,
  input  logic             last,
  input  logic             nxt,
  input  logic             dir,
  input  logic             own,
  input  logic             rsp_ready,
  output seq_state_e       state,
  output logic [IDX_W-1:0] idx
);
  seq_state_e       state_n;
  logic [IDX_W-1:0] idx_n;

  always_comb begin
    state_n = state;
    idx_n   = idx;
    unique case (state)
      ST_IDLE: if (req_fire) begin
        state_n = ST_SEND;
        idx_n   = '0;
      end
      ST_SEND: begin
        if (dir) begin
          state_n = ST_HOLD;
          idx_n   = '0;
        end else if (nxt) begin
          if (last) state_n = rd ? ST_RD_WAIT : ST_STOP;
          else      idx_n   = idx + 1'b1;
        end
      end
      ST_HOLD:    if (own) state_n = ST_SEND;
      ST_RD_WAIT: if (dir) state_n = ST_RD_CAP;
      ST_RD_CAP:  state_n = ST_RD_END;
      ST_RD_END:  if (!dir) state_n = ST_RESP;
      ST_STOP:    state_n = ST_RESP;
      ST_RESP:    if (rsp_ready) state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= state_n;
      idx   <= idx_n;
    end
  end
endmodule

// File: rtl/ulpi_regseq.sv
module ulpi_regseq
  import ulpi_regseq_pkg::*;
#(
  parameter logic [SHORT_W-1:0] EXT_CODE = 6'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rd,
  input  logic [BYTE_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_rdata,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [BYTE_W-1:0] ulpi_data_i,
  output logic [BYTE_W-1:0] ulpi_data_o,
  output logic              ulpi_data_oe,
  output logic              ulpi_stp
);
  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              own;
  logic              req_fire;
  logic              last;
  logic [BYTE_W-1:0] tx_byte;
  access_t           acc;
  logic [BYTE_W-1:0] rdata_q;

  ulpi_regseq_own u_own (
    .clk   (clk),
    .rst_n (rst_n),
    .dir   (ulpi_dir),
    .own   (own)
  );

  ulpi_regseq_enc #(.EXT_CODE(EXT_CODE)) u_enc (
    .acc     (acc),
    .idx     (idx),
    .tx_byte (tx_byte),
    .last    (last)
  );

  ulpi_regseq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .rd        (acc.rd),
    .last      (last),
    .nxt       (ulpi_nxt),
    .dir       (ulpi_dir),
    .own       (own),
    .rsp_ready (rsp_ready),
    .state     (state),
    .idx       (idx)
  );

  assign req_ready = (state == ST_IDLE) && own;
  assign req_fire  = req_valid && req_ready;

  // request capture and read data register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      rdata_q <= '0;
    end else if (req_fire) begin
      acc     <= '{rd: req_rd, addr: req_addr, wdata: req_wdata};
      rdata_q <= '0;
    end else if (state == ST_RD_CAP) begin
      rdata_q <= ulpi_data_i;
    end
  end

  assign ulpi_data_o  = (state == ST_SEND) ? tx_byte : '0;
  assign ulpi_data_oe = own;
  assign ulpi_stp     = (state == ST_STOP);
  assign rsp_valid    = (state == ST_RESP);
  assign rsp_rdata    = rdata_q;
endmodule

// File: rtl/ulpi_regseq_chk.sv
module ulpi_regseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ulpi_dir,
  input logic       ulpi_nxt,
  input logic       ulpi_stp,
  input logic [7:0] ulpi_data_o,
  input logic       ulpi_data_oe,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata
);
  logic dir_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_prev <= 1'b0;
    else        dir_prev <= ulpi_dir;
  end

  // R8
  drive_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_data_oe |-> (!ulpi_dir && !dir_prev));

  // R5
  stp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |=> !ulpi_stp);

  // R5
  stp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |-> (ulpi_data_o == 8'h00));

  // R4
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_data_oe && ulpi_data_o != 8'h00 && !ulpi_nxt && !ulpi_stp)
      |=> $stable(ulpi_data_o));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R9
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !ulpi_stp));
endmodule

bind ulpi_regseq ulpi_regseq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ulpi_dir     (ulpi_dir),
  .ulpi_nxt     (ulpi_nxt),
  .ulpi_stp     (ulpi_stp),
  .ulpi_data_o  (ulpi_data_o),
  .ulpi_data_oe (ulpi_data_oe),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata)
);

// File: tb/ulpi_regseq_test.sv
`timescale 1ns/1ps
module ulpi_regseq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, req_rd;
  logic [7:0] req_addr, req_wdata;
  logic       rsp_valid, rsp_ready;
  logic [7:0] rsp_rdata;
  logic       ulpi_dir, ulpi_nxt, ulpi_data_oe, ulpi_stp;
  logic [7:0] ulpi_data_i, ulpi_data_o;

  always #4 clk = ~clk;

  ulpi_regseq uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_data_i(ulpi_data_i),
    .ulpi_data_o(ulpi_data_o), .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit tmo    = 1'b0;

  // reference model: phase 0 idle, 1 sending, 2 read wait, 3 read data,
  // 4 read end, 5 stop, 6 response, 7 abandoned
  int         ph = 0;
  logic [7:0] mq[$];
  logic [7:0] mfull[$];
  logic       mdq = 1'b0;
  logic [7:0] mrdata = 8'h00;
  logic [7:0] exp_read = 8'h00;
  bit         m_ext, stall, retried, pending, txn_done;
  logic [7:0] phy_reg [256];
  int         abort_left = 0;
  int         idle_burst = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string byte_tag();
    if (stall)        return "R4";
    if (retried && mq.size() == mfull.size()) return "R7";
    if (req_rd)       return "R3";
    return m_ext ? "R2" : "R1";
  endfunction

  task automatic compare();
    bit own_e;
    logic [7:0] d_e;
    own_e = !ulpi_dir && !mdq;
    chk(ulpi_data_oe == own_e, "R8", "data_oe", ulpi_data_oe, own_e);
    if (own_e) begin
      d_e = (ph == 1) ? mq[0] : 8'h00;
      chk(ulpi_data_o == d_e, (ph == 1) ? byte_tag() : (ph == 5 ? "R5" : "R8"),
          "data_o", ulpi_data_o, d_e);
    end
    chk(ulpi_stp == (ph == 5), "R5", "stp", ulpi_stp, ph == 5);
    chk(req_ready == (ph == 0 && own_e), "R9", "req_ready", req_ready, ph == 0 && own_e);
    chk(rsp_valid == (ph == 6), "R10", "rsp_valid", rsp_valid, ph == 6);
    if (ph == 6) begin
      chk(rsp_rdata == mrdata, req_rd ? "R6" : "R10", "rsp_rdata", rsp_rdata, mrdata);
      if (req_rd) chk(rsp_rdata == exp_read, "R6", "register content", rsp_rdata, exp_read);
    end
  endtask

  task automatic mupdate();
    case (ph)
      0: if (req_valid && !ulpi_dir && !mdq) begin
           m_ext = (req_addr >= 8'h2F);
           mfull.delete();
           mfull.push_back({1'b1, req_rd, m_ext ? 6'h2F : req_addr[5:0]});
           if (m_ext)   mfull.push_back(req_addr);
           if (!req_rd) mfull.push_back(req_wdata);
           mq = mfull;
           exp_read = phy_reg[req_addr];
           mrdata = 8'h00; pending = 0; retried = 0; stall = 0; ph = 1;
         end
      1: if (ulpi_dir) begin
           ph = 7; mq = mfull; retried = 1; stall = 0;
         end else if (ulpi_nxt) begin
           if (mq.size() == 1 && !req_rd) phy_reg[req_addr] = req_wdata;
           void'(mq.pop_front());
           stall = 0;
           if (mq.size() == 0) ph = req_rd ? 2 : 5;
         end else stall = 1;
      7: if (!ulpi_dir && !mdq) ph = 1;
      2: if (ulpi_dir) ph = 3;
      3: begin mrdata = ulpi_data_i; ph = 4; end
      4: if (!ulpi_dir) ph = 6;
      5: ph = 6;
      6: if (rsp_ready) begin ph = 0; txn_done = 1; end
      default: ph = 0;
    endcase
    mdq = ulpi_dir;
  endtask

  task automatic plan_inputs();
    ulpi_dir    = 1'b0;
    ulpi_nxt    = 1'b0;
    ulpi_data_i = 8'($urandom);
    req_valid   = pending;
    rsp_ready   = ($urandom_range(0, 1) == 1);
    case (ph)
      0: begin
           if (idle_burst == 0 && $urandom_range(0, 9) == 0) idle_burst = $urandom_range(1, 3);
           if (idle_burst > 0) begin ulpi_dir = 1'b1; idle_burst--; end
         end
      1: begin
           if (abort_left == 0 && mq.size() == mfull.size() && $urandom_range(0, 3) == 0)
             abort_left = $urandom_range(1, 3);
           if (abort_left > 0) begin
             ulpi_dir = 1'b1; ulpi_nxt = 1'b1; abort_left--;
           end else ulpi_nxt = ($urandom_range(0, 2) != 0);
         end
      7: if (abort_left > 0) begin ulpi_dir = 1'b1; abort_left--; end
      2: ulpi_dir = ($urandom_range(0, 2) != 0);
      3: begin ulpi_dir = 1'b1; ulpi_data_i = phy_reg[req_addr]; end
      4: ulpi_dir = ($urandom_range(0, 2) == 0);
      default: ;
    endcase
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    @(posedge clk);
    #1;
    mupdate();
    cyc++;
    if (cyc >= 150000) tmo = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) phy_reg[i] = 8'(i) ^ 8'hA5;
    rst_n = 1'b0; req_valid = 0; req_rd = 0; req_addr = 0; req_wdata = 0;
    rsp_ready = 0; ulpi_dir = 0; ulpi_nxt = 0; ulpi_data_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ulpi_data_oe == 1'b1, "R11", "data_oe after reset", ulpi_data_oe, 1);
    chk(ulpi_data_o == 8'h00, "R11", "data_o after reset", ulpi_data_o, 0);
    chk(ulpi_stp == 1'b0, "R11", "stp after reset", ulpi_stp, 0);
    chk(req_ready == 1'b1, "R11", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", rsp_valid, 0);
    @(posedge clk);
    #1 mupdate();

    for (int t = 0; t < 600 && !tmo; t++) begin
      case ($urandom_range(0, 3))
        0: req_addr = 8'($urandom_range(0, 8'h2E));
        1: req_addr = ($urandom_range(0, 1) == 1) ? 8'h2E : 8'h2F;
        2: req_addr = 8'($urandom_range(8'h2F, 8'hFF));
        default: req_addr = 8'($urandom_range(0, 3));
      endcase
      req_rd    = ($urandom_range(0, 1) == 1);
      req_wdata = 8'($urandom);
      pending   = 1;
      txn_done  = 0;
      while (!txn_done && !tmo) begin
        plan_inputs();
        tick();
      end
    end

    if (tmo) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule